// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides, cycle by cycle, how a small 32-bit RISC core enters and leaves its exception handlers. The core presents a request vector, with one bit per exception kind, together with the program counter of the faulting or interrupted instruction. The block picks one request and saves that program counter into the return register of the request's class. It then updates the interrupt-enable bits and issues a registered redirect carrying the handler address.

Exceptions fall into two classes. The ordinary class covers instruction bus error, data bus error, divide by zero, external interrupt and system call. It saves into the exception return register and the exception saved-enable bit. The debug class covers breakpoint and watchpoint. It saves into the breakpoint return register and the breakpoint saved-enable bit. Handler addresses sit 32 bytes apart above a base register. Debug requests always use the debug base. Ordinary requests use the normal base unless a remap flag sends them to the debug base as well.

Two return inputs reload the program counter from the matching return register and restore the enable bit. Software sets the bases, the enable bits and the remap flag through a single write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, redirect_valid and abort are 0, and ie_bits, dc_remap, ea, ba, eba and deba all read zero.
- R2: An accepted ordinary request (codes 2 instruction bus error, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call) loads ea with pc_in and leaves ba unchanged.
- R3: An accepted debug request (code 1 breakpoint, code 3 watchpoint) loads ba with pc_in and leaves ea unchanged.
- R4: The handler address is base + code*32. Debug requests always take deba as the base. Ordinary requests take eba while dc_remap is 0 and deba while it is 1.
- R5: On an ordinary entry, ie_bits[1] (saved exception enable) takes ie_bits[0] and ie_bits[0] clears. On a debug entry, ie_bits[2] (saved debug enable) takes ie_bits[0] and ie_bits[0] clears. The other saved bit is left unchanged.
- R6: Bit i of exc_req requests code i. When several bits are set in one cycle, the lowest set index wins.
- R7: The interrupt bit (exc_req[6]) is ignored while ie_bits[0] is 0.
- R8: Bit 0 of exc_req (code 0, the reset code) is not a valid entry. When it wins, abort pulses for one cycle, no redirect is issued, and ea, ba and ie_bits are unchanged.
- R9: With no request pending, eret redirects to ea and copies ie_bits[1] into ie_bits[0]. bret does the same from ba and ie_bits[2]. A request has priority over both, and eret has priority over bret.
- R10: When csr_we is set, csr_sel selects the target: 0 eba, 1 deba, 2 ie_bits (written from csr_wdata[2:0]), 3 dc_remap (written from csr_wdata[0]). The low 8 bits of eba and deba always read zero. An ie_bits write is dropped in a cycle where an entry, eret or bret is taken.
- R11: redirect_valid is a single-cycle pulse at the clock edge after an entry or return is accepted, and redirect_pc is valid while the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 8 | Request vector, bit i requests code i |
| pc_in | input | 32 | Program counter to save on entry |
| eret | input | 1 | Return from an ordinary exception |
| bret | input | 1 | Return from a debug exception |
| csr_we | input | 1 | Control register write strobe |
| csr_sel | input | 2 | Write target: 0 eba, 1 deba, 2 ie, 3 remap |
| csr_wdata | input | 32 | Write data |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | New program counter |
| abort | output | 1 | One-cycle pulse for an invalid request code |
| ea | output | 32 | Ordinary-exception return address |
| ba | output | 32 | Debug-exception return address |
| ie_bits | output | 3 | {saved debug enable, saved exception enable, enable} |
| dc_remap | output | 1 | Ordinary exceptions use the debug base |
| eba | output | 32 | Normal vector base |
| deba | output | 32 | Debug vector base |

## Verification
Single requests from each class show which return register and which saved-enable bit are written, and whether the base comes from eba or deba. The same ordinary request is repeated with the remap flag set to show the base switch. Multi-bit vectors such as watchpoint with divide by zero, or reset code with system call, exercise the lowest-index rule and the abort path. An interrupt raised with the enable bit cleared must give no redirect. Cycles where a request, a return and an enable write arrive together show which one wins.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN        = 32;
  localparam int NUM_CODES   = 8;
  localparam int CODE_W      = $clog2(NUM_CODES);
  localparam int VEC_SHIFT   = 5;
  localparam int BASE_ZEROS  = 8;
  localparam int SEL_W       = 2;
  localparam int IE_W        = 3;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET   = 3'd0,
    EXC_BRKPT   = 3'd1,
    EXC_IBUS    = 3'd2,
    EXC_WATCH   = 3'd3,
    EXC_DBUS    = 3'd4,
    EXC_DIVZERO = 3'd5,
    EXC_IRQ     = 3'd6,
    EXC_SYSCALL = 3'd7
  } exc_code_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_EBA  = 2'd0,
    SEL_DEBA = 2'd1,
    SEL_IE   = 2'd2,
    SEL_DC   = 2'd3
  } csr_sel_e;

  function automatic logic code_is_debug(input logic [CODE_W-1:0] code);
    return (code == EXC_BRKPT) || (code == EXC_WATCH);
  endfunction

  function automatic logic [XLEN-1:0] handler_addr(input logic [XLEN-1:0] base,
                                                    input logic [CODE_W-1:0] code);
    return base + (XLEN'(code) << VEC_SHIFT);
  endfunction

  function automatic logic [XLEN-1:0] align_base(input logic [XLEN-1:0] raw);
    return {raw[XLEN-1:BASE_ZEROS], {BASE_ZEROS{1'b0}}};
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N  = exc_pkg::NUM_CODES,
  parameter int CW = exc_pkg::CODE_W
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [CW-1:0] code
);
  always_comb begin
    any  = |req;
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = CW'(i);
    end
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [SEL_W-1:0] csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  input  logic             take_exc,
  input  logic             take_dbg,
  input  logic             take_eret,
  input  logic             take_bret,
  input  logic [XLEN-1:0]  pc_in,
  output logic [XLEN-1:0]  eba,
  output logic [XLEN-1:0]  deba,
  output logic             dc_remap,
  output logic [IE_W-1:0]  ie_bits,
  output logic [XLEN-1:0]  ea,
  output logic [XLEN-1:0]  ba
);
  logic ie_q, eie_q, bie_q;
  logic ie_wr_ok;

  assign ie_wr_ok = csr_we && (csr_sel == SEL_IE) && !take_exc && !take_eret && !take_bret;
  assign ie_bits  = {bie_q, eie_q, ie_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eba      <= '0;
      deba     <= '0;
      dc_remap <= 1'b0;
    end else if (csr_we) begin
      case (csr_sel)
        SEL_EBA:  eba      <= align_base(csr_wdata);
        SEL_DEBA: deba     <= align_base(csr_wdata);
        SEL_DC:   dc_remap <= csr_wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea <= '0;
      ba <= '0;
    end else if (take_exc) begin
      if (take_dbg) ba <= pc_in;
      else          ea <= pc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      eie_q <= 1'b0;
      bie_q <= 1'b0;
    end else if (take_exc) begin
      if (take_dbg) bie_q <= ie_q;
      else          eie_q <= ie_q;
      ie_q <= 1'b0;
    end else if (take_eret) begin
      ie_q <= eie_q;
    end else if (take_bret) begin
      ie_q <= bie_q;
    end else if (ie_wr_ok) begin
      ie_q  <= csr_wdata[0];
      eie_q <= csr_wdata[1];
      bie_q <= csr_wdata[2];
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CODES-1:0]  exc_req,
  input  logic [XLEN-1:0]       pc_in,
  input  logic                  eret,
  input  logic                  bret,
  input  logic                  csr_we,
  input  logic [SEL_W-1:0]      csr_sel,
  input  logic [XLEN-1:0]       csr_wdata,
  output logic                  redirect_valid,
  output logic [XLEN-1:0]       redirect_pc,
  output logic                  abort,
  output logic [XLEN-1:0]       ea,
  output logic [XLEN-1:0]       ba,
  output logic [IE_W-1:0]       ie_bits,
  output logic                  dc_remap,
  output logic [XLEN-1:0]       eba,
  output logic [XLEN-1:0]       deba
);
  logic [NUM_CODES-1:0] req_eff;
  logic                 req_any;
  logic [CODE_W-1:0]    take_code;
  logic                 take_exc, take_dbg, take_abort, take_eret, take_bret;
  logic [XLEN-1:0]      entry_base;

  always_comb begin
    req_eff = exc_req;
    if (!ie_bits[0]) req_eff[EXC_IRQ] = 1'b0;
  end

  exc_arbiter #(.N(NUM_CODES), .CW(CODE_W)) u_arb (
    .req  (req_eff),
    .any  (req_any),
    .code (take_code)
  );

  assign take_abort = req_any && (take_code == EXC_RESET);
  assign take_exc   = req_any && (take_code != EXC_RESET);
  assign take_dbg   = take_exc && code_is_debug(take_code);
  assign take_eret  = !req_any && eret;
  assign take_bret  = !req_any && !eret && bret;
  assign entry_base = (take_dbg || dc_remap) ? deba : eba;

  exc_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_sel   (csr_sel),
    .csr_wdata (csr_wdata),
    .take_exc  (take_exc),
    .take_dbg  (take_dbg),
    .take_eret (take_eret),
    .take_bret (take_bret),
    .pc_in     (pc_in),
    .eba       (eba),
    .deba      (deba),
    .dc_remap  (dc_remap),
    .ie_bits   (ie_bits),
    .ea        (ea),
    .ba        (ba)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      abort          <= 1'b0;
    end else begin
      redirect_valid <= take_exc || take_eret || take_bret;
      abort          <= take_abort;
      if (take_exc)       redirect_pc <= handler_addr(entry_base, take_code);
      else if (take_eret) redirect_pc <= ea;
      else if (take_bret) redirect_pc <= ba;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_in,
  input logic              take_exc,
  input logic              take_dbg,
  input logic              take_eret,
  input logic              take_bret,
  input logic [CODE_W-1:0] take_code,
  input logic              redirect_valid,
  input logic [XLEN-1:0]   redirect_pc,
  input logic              abort,
  input logic [XLEN-1:0]   ea,
  input logic [XLEN-1:0]   ba,
  input logic [IE_W-1:0]   ie_bits,
  input logic [XLEN-1:0]   eba,
  input logic [XLEN-1:0]   deba
);
  AST_EA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && !take_dbg) |=> (ea == $past(pc_in)));  // R2
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> (ba == $past(pc_in)));  // R3
  AST_VEC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (redirect_pc[VEC_SHIFT-1:0] == '0));  // R4
  AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> !ie_bits[0]);  // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && take_code == EXC_IRQ) |-> ie_bits[0]);  // R7
  AST_ABORT_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !redirect_valid);  // R8
  AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (eba[BASE_ZEROS-1:0] == '0) && (deba[BASE_ZEROS-1:0] == '0));  // R10
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc || take_eret || take_bret) |=> redirect_valid);  // R11
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_exc && !take_eret && !take_bret) |=> !redirect_valid);  // R11
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pc_in          (pc_in),
  .take_exc       (take_exc),
  .take_dbg       (take_dbg),
  .take_eret      (take_eret),
  .take_bret      (take_bret),
  .take_code      (take_code),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .abort          (abort),
  .ea             (ea),
  .ba             (ba),
  .ie_bits        (ie_bits),
  .eba            (eba),
  .deba           (deba)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  exc_req = '0;
  logic [31:0] pc_in = '0;
  logic        eret = 1'b0, bret = 1'b0, csr_we = 1'b0;
  logic [1:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic        redirect_valid, abort, dc_remap;
  logic [31:0] redirect_pc, ea, ba, eba, deba;
  logic [2:0]  ie_bits;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u0 (.*);

  typedef struct {
    logic        rv;
    logic [31:0] rpc;
    logic        ab;
    logic [31:0] ea;
    logic [31:0] ba;
    logic [2:0]  ie;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_ea = 0, m_ba = 0, m_eba = 0, m_deba = 0;
  logic        m_ie = 0, m_eie = 0, m_bie = 0, m_dc = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] rq, input logic [31:0] pc, input logic e,
                      input logic b, input logic we, input logic [1:0] sel,
                      input logic [31:0] wd, input string tag);
    exp_t it;
    logic [7:0] eff;
    int low;
    @(negedge clk);
    exc_req = rq; pc_in = pc; eret = e; bret = b;
    csr_we = we; csr_sel = sel; csr_wdata = wd;
    eff = rq;
    if (!m_ie) eff[6] = 1'b0;
    low = -1;
    for (int i = 7; i >= 0; i--) if (eff[i]) low = i;
    it.rv = 0; it.ab = 0; it.rpc = 'x;
    if (low == 0) it.ab = 1;
    else if (low > 0) begin
      it.rv = 1;
      if (low == 1 || low == 3) begin
        m_ba = pc; m_bie = m_ie; it.rpc = m_deba + 32'(low * 32);
      end else begin
        m_ea = pc; m_eie = m_ie; it.rpc = (m_dc ? m_deba : m_eba) + 32'(low * 32);
      end
      m_ie = 0;
    end else if (e) begin
      it.rv = 1; it.rpc = m_ea; m_ie = m_eie;
    end else if (b) begin
      it.rv = 1; it.rpc = m_ba; m_ie = m_bie;
    end
    if (we) begin
      case (sel)
        2'd0: m_eba  = wd & 32'hFFFF_FF00;
        2'd1: m_deba = wd & 32'hFFFF_FF00;
        2'd2: if (low <= 0 && !(low < 0 && (e || b))) {m_bie, m_eie, m_ie} = wd[2:0];
        default: m_dc = wd[0];
      endcase
    end
    it.ea = m_ea; it.ba = m_ba; it.ie = {m_bie, m_eie, m_ie}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(8'h00, 32'h0, 0, 0, 0, 2'd0, 32'h0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() != 0) begin
      exp_t it;
      it = sb.pop_front();
      check(it.tag, "redirect_valid", 32'(redirect_valid), 32'(it.rv));
      check(it.tag, "abort", 32'(abort), 32'(it.ab));
      if (it.rv) check(it.tag, "redirect_pc", redirect_pc, it.rpc);
      check(it.tag, "ea", ea, it.ea);
      check(it.tag, "ba", ba, it.ba);
      check(it.tag, "ie_bits", 32'(ie_bits), 32'(it.ie));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "redirect_valid", 32'(redirect_valid), 0);
    check("R1", "abort", 32'(abort), 0);
    check("R1", "ie_bits", 32'(ie_bits), 0);
    check("R1", "ea|ba|eba|deba", ea | ba | eba | deba, 0);
    check("R1", "dc_remap", 32'(dc_remap), 0);
    rst_n = 1'b1;
    // R10 base writes drop the low 8 bits
    step(8'h00, 0, 0, 0, 1, 2'd0, 32'h1000_00FF, "R10");
    step(8'h00, 0, 0, 0, 1, 2'd1, 32'h2000_0A5C, "R10");
    idle("R10");
    check("R10", "eba", eba, 32'h1000_0000);
    check("R10", "deba", deba, 32'h2000_0A00);
    step(8'h00, 0, 0, 0, 1, 2'd2, 32'h1, "R10");
    // R2 R4 R5 system call with enable set
    step(8'h80, 32'h0000_0100, 0, 0, 0, 2'd0, 0, "R2");
    idle("R11");
    // R9 eret
    step(8'h00, 0, 1, 0, 0, 2'd0, 0, "R9");
    // R7 interrupt accepted while enabled
    step(8'h40, 32'h0000_0200, 0, 0, 0, 2'd0, 0, "R7");
    // R7 interrupt ignored while disabled (enable is 0 now)
    step(8'h40, 32'h0000_0300, 0, 0, 0, 2'd0, 0, "R7");
    step(8'h00, 0, 1, 0, 0, 2'd0, 0, "R9");
    // R3 R6 watchpoint beats divide by zero
    step(8'h28, 32'h0000_0400, 0, 0, 0, 2'd0, 0, "R6");
    step(8'h00, 0, 0, 1, 0, 2'd0, 0, "R9");
    // R6 data bus error beats divide by zero
    step(8'h30, 32'h0000_0500, 0, 0, 0, 2'd0, 0, "R6");
    // R4 remap sends ordinary entries to deba
    step(8'h00, 0, 0, 0, 1, 2'd3, 32'h1, "R4");
    step(8'h04, 32'h0000_0600, 0, 0, 0, 2'd0, 0, "R4");
    // R8 reset code and reset code beating system call
    step(8'h01, 32'h0000_0700, 0, 0, 0, 2'd0, 0, "R8");
    step(8'h81, 32'h0000_0800, 0, 0, 0, 2'd0, 0, "R8");
    // R10 enable write lost to an entry in the same cycle
    step(8'h00, 0, 0, 0, 1, 2'd2, 32'h7, "R10");
    step(8'h02, 32'h0000_0900, 0, 0, 1, 2'd2, 32'h1, "R10");
    // R9 eret and bret together: eret wins
    step(8'h00, 0, 1, 1, 0, 2'd0, 0, "R9");
    // R5 breakpoint with enable set saves into the debug bit
    step(8'h02, 32'h0000_0A00, 0, 0, 0, 2'd0, 0, "R5");
    // R9 request beats eret
    step(8'h10, 32'h0000_0B00, 1, 0, 0, 2'd0, 0, "R9");
    idle("R11");
    idle("R11");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule